// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Arithmetic Unit

This block computes everything a processor needs for one stack operation except the memory transfer itself. Five operations are handled: push, pop, push of the program counter, pop of the program counter, and a signed adjust. Each operation takes the 36-bit stack pointer, the 30-bit program counter (a 12-bit section over an 18-bit word) and, where needed, an adjust amount or the word that was popped. It returns the 30-bit memory address of the access, the next pointer value, the word to write for a PC push, the PC to resume at after a PC pop, and an overflow flag.

The pointer is read in one of two modes. A pointer whose left half is zero or negative is a local pointer. Its two 18-bit halves step together, and the right half addresses a word inside the section the PC is running in. A pointer whose left half is positive and nonzero holds a flat 30-bit global address. That address steps by exactly one and carries no space count. Code running in section 0 always uses the local mode. Results are registered and appear one cycle after a valid request.

Top module: `spu_stack_ptr`

## Requirements
- R1: Mode is chosen from the incoming pointer, before it is stepped: global when the PC section is nonzero and the left half (bits 35..18) has bit 35 clear and is nonzero; local otherwise.
- R2: A local access addresses {PC section, right half}. Push and push-PC use the stepped right half. Pop and pop-PC use the incoming right half.
- R3: With PC section 0 the pointer is always local, so the address section is 0 even if the left half is positive.
- R4: A local push adds 1 and a local pop subtracts 1 to each 18-bit half independently, modulo 2^18, with no carry between halves.
- R5: A global push or pop adds or subtracts 1 on bits 29..0 modulo 2^30, leaving bits 35..30 unchanged. The address is bits 29..0 of the stepped pointer for a push and of the incoming pointer for a pop.
- R6: Push-PC steps and addresses like push and outputs a write word equal to the 30-bit PC with bits 35..30 zero. Every other operation outputs a write word of 0.
- R7: Pop-PC steps and addresses like pop and outputs a PC equal to bits 29..0 of the popped word. Every other operation passes the incoming PC through.
- R8: In local mode overflow is raised when a push leaves the left half at 0, or when a pop starts from a left half of 0.
- R9: A global pointer never raises overflow.
- R10: Adjust adds the sign-extended 18-bit amount to each half independently in local mode, and to bits 29..0 in global mode (bits 35..30 unchanged). Its address output is 0.
- R11: A local adjust raises overflow when bit 35 of the pointer differs before and after; a global adjust never does.
- R12: Operation codes: 0 push, 1 pop, 2 push-PC, 3 pop-PC, 4 adjust. Codes 5 to 7 return the pointer unchanged, address 0 and no overflow.
- R13: Results are registered. They appear with valid_o one cycle after valid_i and hold when valid_i is low. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| sp_i | input | 36 | Current stack pointer |
| pc_i | input | 30 | Current PC, section in bits 29..18 |
| adj_i | input | 18 | Signed adjust amount |
| pop_word_i | input | 36 | Word read from the stack for a PC pop |
| valid_o | output | 1 | Result strobe |
| addr_o | output | 30 | Stack access address |
| sp_o | output | 36 | Updated stack pointer |
| wdata_o | output | 36 | Word to store for a PC push |
| pc_o | output | 30 | PC after the operation |
| ovf_o | output | 1 | Stack overflow flag |

## Verification
The bench builds the unit with its default 18-bit halves and 12-bit section. At these widths every wrap boundary can be driven directly: the left half stepping from all ones to zero, a global pointer wrapping at 2^30, and a right half wrapping without disturbing the left. Directed cases cover section 0 against positive left halves, both overflow edges, negative adjusts in each mode and the unused operation codes. Long runs of random requests then mix the modes so that the PC section, the adjust sign and the pointer sign bits change from cycle to cycle.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [2:0] {
    OP_PUSH    = 3'd0,
    OP_POP     = 3'd1,
    OP_PUSH_PC = 3'd2,
    OP_POP_PC  = 3'd3,
    OP_ADJ     = 3'd4
  } spu_op_e;
endpackage

// File: rtl/spu_mode_dec.sv
module spu_mode_dec #(
  parameter int HALF_W = 18,
  parameter int SEC_W  = 12
) (
  input  logic [HALF_W-1:0] lh_i,
  input  logic [SEC_W-1:0]  pc_sec_i,
  output logic              global_o
);
  // positive nonzero left half, outside section 0
  assign global_o = (|pc_sec_i) && !lh_i[HALF_W-1] && (|lh_i);
endmodule

// File: rtl/spu_step.sv
module spu_step #(
  parameter int HALF_W = 18,
  parameter int SEC_W  = 12,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = SEC_W + HALF_W
) (
  input  logic [WORD_W-1:0] sp_i,
  input  logic              global_i,
  input  logic [HALF_W-1:0] delta_i,
  output logic [WORD_W-1:0] sp_o
);
  logic [HALF_W-1:0] loc_half [2];
  logic [ADDR_W-1:0] glb_addr;

  // local: each half stepped on its own lane, no carry between
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign loc_half[h] = sp_i[h*HALF_W +: HALF_W] + delta_i;
  end

  assign glb_addr = sp_i[ADDR_W-1:0] + {{SEC_W{delta_i[HALF_W-1]}}, delta_i};

  always_comb begin
    if (global_i) sp_o = {sp_i[WORD_W-1:ADDR_W], glb_addr};
    else          sp_o = {loc_half[1], loc_half[0]};
  end
endmodule

// File: rtl/spu_pcx.sv
module spu_pcx #(
  parameter int HALF_W = 18,
  parameter int SEC_W  = 12,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = SEC_W + HALF_W
) (
  input  logic              push_pc_i,
  input  logic              pop_pc_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WORD_W-1:0] pop_word_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] pc_o
);
  assign wdata_o = push_pc_i ? {{(WORD_W-ADDR_W){1'b0}}, pc_i} : '0;
  assign pc_o    = pop_pc_i  ? pop_word_i[ADDR_W-1:0] : pc_i;
endmodule

// File: rtl/spu_stack_ptr.sv
module spu_stack_ptr #(
  parameter int HALF_W = 18,
  parameter int SEC_W  = 12,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = SEC_W + HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [HALF_W-1:0] adj_i,
  input  logic [WORD_W-1:0] pop_word_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ovf_o
);
  import spu_pkg::*;

  spu_op_e           op;
  logic              is_push, is_pop, is_adj, is_glb;
  logic [HALF_W-1:0] delta, old_lh, new_lh;
  logic [SEC_W-1:0]  pc_sec;
  logic [WORD_W-1:0] new_sp, ptr_sel, wdata_n;
  logic [ADDR_W-1:0] addr_n, pc_n;
  logic              ovf_n;

  assign op      = spu_op_e'(op_i);
  assign pc_sec  = pc_i[ADDR_W-1:HALF_W];
  assign old_lh  = sp_i[WORD_W-1:HALF_W];
  assign is_push = (op == OP_PUSH) || (op == OP_PUSH_PC);
  assign is_pop  = (op == OP_POP)  || (op == OP_POP_PC);
  assign is_adj  = (op == OP_ADJ);

  always_comb begin
    delta = '0;
    if (is_push)     delta = {{(HALF_W-1){1'b0}}, 1'b1};
    else if (is_pop) delta = '1;
    else if (is_adj) delta = adj_i;
  end

  spu_mode_dec #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_mode (
    .lh_i(old_lh), .pc_sec_i(pc_sec), .global_o(is_glb)
  );

  spu_step #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_step (
    .sp_i(sp_i), .global_i(is_glb), .delta_i(delta), .sp_o(new_sp)
  );

  spu_pcx #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_pcx (
    .push_pc_i(op == OP_PUSH_PC), .pop_pc_i(op == OP_POP_PC),
    .pc_i(pc_i), .pop_word_i(pop_word_i), .wdata_o(wdata_n), .pc_o(pc_n)
  );

  assign new_lh  = new_sp[WORD_W-1:HALF_W];
  // push is pre-increment, pop is post-decrement
  assign ptr_sel = is_push ? new_sp : sp_i;

  always_comb begin
    addr_n = '0;
    if (is_push || is_pop)
      addr_n = is_glb ? ptr_sel[ADDR_W-1:0] : {pc_sec, ptr_sel[HALF_W-1:0]};
  end

  always_comb begin
    ovf_n = 1'b0;
    if (!is_glb) begin
      if (is_push && (new_lh == '0)) ovf_n = 1'b1;
      if (is_pop  && (old_lh == '0)) ovf_n = 1'b1;
      if (is_adj  && (old_lh[HALF_W-1] != new_lh[HALF_W-1])) ovf_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      sp_o    <= '0;
      wdata_o <= '0;
      pc_o    <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o  <= addr_n;
        sp_o    <= new_sp;
        wdata_o <= wdata_n;
        pc_o    <= pc_n;
        ovf_o   <= ovf_n;
      end
    end
  end
endmodule

// File: rtl/spu_stack_ptr_chk.sv
module spu_stack_ptr_chk #(
  parameter int HALF_W = 18,
  parameter int SEC_W  = 12,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = SEC_W + HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [WORD_W-1:0] sp_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [WORD_W-1:0] pop_word_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [WORD_W-1:0] sp_o,
  input logic [WORD_W-1:0] wdata_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ovf_o
);
  logic in_glb, in_sec0;
  assign in_sec0 = (pc_i[ADDR_W-1:HALF_W] == '0);
  assign in_glb  = !in_sec0 && !sp_i[WORD_W-1] && (sp_i[WORD_W-1:HALF_W] != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && in_glb) |-> !ovf_o); // R9

  AST_PC_PUSH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && op_i == 3'd2) |->
      wdata_o == {{(WORD_W-ADDR_W){1'b0}}, $past(pc_i)}); // R6

  AST_SEC0_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && in_sec0 && op_i <= 3'd3) |->
      addr_o[ADDR_W-1:HALF_W] == '0); // R3

  AST_PC_POP_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && op_i == 3'd3) |->
      pc_o == $past(pop_word_i[ADDR_W-1:0])); // R7

  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_i && op_i > 3'd4) |->
      sp_o == $past(sp_i) && !ovf_o && addr_o == '0); // R12

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(sp_o) && $stable(addr_o)); // R13
endmodule

bind spu_stack_ptr spu_stack_ptr_chk #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .sp_i(sp_i), .pc_i(pc_i), .pop_word_i(pop_word_i), .valid_o(valid_o),
  .addr_o(addr_o), .sp_o(sp_o), .wdata_o(wdata_o), .pc_o(pc_o), .ovf_o(ovf_o)
);

// File: tb/sim_spu_stack_ptr.sv
module sim_spu_stack_ptr;
  localparam longint M18 = 64'h3FFFF;
  localparam longint M30 = 64'h3FFFFFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [35:0] sp_i = '0;
  logic [29:0] pc_i = '0;
  logic [17:0] adj_i = '0;
  logic [35:0] pop_word_i = '0;
  logic        valid_o;
  logic [29:0] addr_o;
  logic [35:0] sp_o;
  logic [35:0] wdata_o;
  logic [29:0] pc_o;
  logic        ovf_o;

  int n_cmp = 0;
  int n_bad = 0;

  // expected outputs
  logic        e_valid = 0;
  logic [29:0] e_addr = '0;
  logic [35:0] e_sp = '0;
  logic [35:0] e_wdata = '0;
  logic [29:0] e_pc = '0;
  logic        e_ovf = 0;
  string       t_sp = "R13", t_addr = "R13", t_ovf = "R13";

  spu_stack_ptr u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R13", "valid_o", longint'(valid_o), longint'(e_valid));
    chk(t_addr, "addr_o", longint'(addr_o), longint'(e_addr));
    chk(t_sp, "sp_o", longint'(sp_o), longint'(e_sp));
    chk("R6", "wdata_o", longint'(wdata_o), longint'(e_wdata));
    chk("R7", "pc_o", longint'(pc_o), longint'(e_pc));
    chk(t_ovf, "ovf_o", longint'(ovf_o), longint'(e_ovf));
  endtask

  // behavioural model of one request
  task automatic model(int op, longint sp, longint pc, longint adj, longint pw);
    longint lh = (sp >> 18) & M18;
    longint rh = sp & M18;
    longint sec = (pc >> 18) & 64'hFFF;
    bit glb = (sec != 0) && (lh != 0) && (lh < 64'h20000);
    longint d = 0;
    longint nsp, nlh, ptr;
    bit push = (op == 0 || op == 2);
    bit pop = (op == 1 || op == 3);
    if (push) d = 1;
    else if (pop) d = -1;
    else if (op == 4) d = (adj >= 64'h20000) ? adj - 64'h40000 : adj;
    if (op > 4) d = 0;
    if (glb) nsp = (sp & ~M30 & 64'hFFFFFFFFF) | ((sp + d) & M30);
    else nsp = (((lh + d) & M18) << 18) | ((rh + d) & M18);
    nlh = (nsp >> 18) & M18;
    ptr = push ? nsp : sp;
    e_sp = nsp[35:0];
    e_addr = '0;
    if (push || pop) e_addr = glb ? 30'(ptr & M30) : 30'((sec << 18) | (ptr & M18));
    e_wdata = (op == 2) ? 36'(pc) : '0;
    e_pc = (op == 3) ? 30'(pw & M30) : 30'(pc);
    e_ovf = 0;
    if (!glb) begin
      if (push && nlh == 0) e_ovf = 1;
      if (pop && lh == 0) e_ovf = 1;
      if (op == 4 && (lh >> 17) != (nlh >> 17)) e_ovf = 1;
    end
    if (op > 4) begin t_sp = "R12"; t_addr = "R12"; t_ovf = "R12"; end
    else if (op == 4) begin t_sp = "R10"; t_addr = "R10"; t_ovf = glb ? "R9" : "R11"; end
    else begin
      t_sp = glb ? "R5" : ((sec == 0) ? "R3" : "R4");
      t_addr = glb ? "R5" : ((sec == 0) ? "R3" : "R2");
      t_ovf = glb ? "R9" : "R8";
    end
  endtask

  // one cycle: check last result, then apply the next request
  task automatic step(bit v, int op, longint sp, longint pc, longint adj, longint pw);
    @(negedge clk_i);
    compare_all();
    valid_i = v; op_i = 3'(op); sp_i = 36'(sp); pc_i = 30'(pc);
    adj_i = 18'(adj); pop_word_i = 36'(pw);
    e_valid = v;
    if (v) model(op, sp, pc, adj, pw);
    else t_sp = "R13";
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare_all(); // reset state, R13
    rst_ni = 1'b1;
    // R4 local push in section 3, right half wraps without touching left
    step(1, 0, 64'o777776_777777, 64'o0003_000400, 0, 0);
    // R8 local push reaching zero left half
    step(1, 0, 64'o777777_001000, 64'o0003_000400, 0, 0);
    // R8 local pop from zero left half
    step(1, 1, 64'o000000_000005, 64'o0003_000400, 0, 0);
    // R1 R5 global push and wrap at 2^30
    step(1, 0, 64'o000002_000010, 64'o0003_000400, 0, 0);
    step(1, 0, 64'o007777_777777, 64'o0001_000000, 0, 0);
    step(1, 1, 64'o000001_000000, 64'o0001_000000, 0, 0);
    // R3 section 0 forces local with positive left half
    step(1, 0, 64'o000002_000010, 64'o0000_000400, 0, 0);
    step(1, 1, 64'o000002_000010, 64'o0000_000400, 0, 0);
    // R6 R7 PC push and pop
    step(1, 2, 64'o000004_000100, 64'o0005_123456, 0, 0);
    step(1, 3, 64'o777770_000100, 64'o0005_123456, 0, 64'o777702_345670);
    step(1, 3, 64'o000004_000100, 64'o0005_123456, 0, 64'o123456_765432);
    // R10 R11 adjust local and global, sign crossing
    step(1, 4, 64'o777776_000100, 64'o0002_000000, 5, 0);
    step(1, 4, 64'o000003_000100, 64'o0002_000000, 64'o777770, 0);
    step(1, 4, 64'o000003_000100, 64'o0000_000000, 64'o777770, 0);
    // R12 unused codes
    step(1, 5, 64'o123456_654321, 64'o0002_000000, 7, 0);
    step(1, 7, 64'o000001_000000, 64'o0000_000000, 7, 0);
    // R13 hold while idle
    step(0, 0, 64'o1, 64'o1, 0, 0);
    step(0, 1, 64'o2, 64'o2, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      longint sp = {$urandom, $urandom} & 64'hFFFFFFFFF;
      longint pc = $urandom & M30;
      if (i % 4 == 0) pc = pc & M18;
      if (i % 5 == 0) sp = sp & 64'h7FFFFFFFF;
      if (i % 7 == 0) sp = sp & 64'h00003FFFF | (($urandom % 2) ? 64'hFFFFC0000 : 0);
      step(($urandom % 8) != 0, $urandom % 8, sp, pc, $urandom & M18,
           {$urandom, $urandom} & 64'hFFFFFFFFF);
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule